// File: doc/BRIEF.md
# Bus Fault Watchdog Monitor

This block sits beside a single-layer AHB-style bus and only observes it. It raises nothing on the bus. It watches four kinds of fault:
- after the bus changes owner, it stays idle for too long;
- a transfer in its data phase is left waiting for too long;
- a slave answers with an ERROR response;
- a burst carries more beats than a configured maximum.

Each fault has a 2-bit action field of its own. The field decides whether the fault only records a sticky status bit, also drives the interrupt line, or also requests a chip reset.

Software sets the two timeout limits, the burst limit and the action fields through the configuration inputs. It reads the status bits and clears them by writing ones to the clear input. Bus decoding, arbitration and recovery of a stalled transfer are left to other blocks.

Top module: `busfault_mon`

## Requirements
- R1: When `grant_chg` is high in a cycle, the owner-idle detector arms with a zero count. If HTRANS is then IDLE (2'b00) for `cfg_idle_lim`+1 consecutive cycles after that cycle, event 0 fires once, in the last of those cycles.
- R2: The owner-idle detector disarms at the first non-IDLE HTRANS after the grant change. Further IDLE cycles do not fire event 0 until the next `grant_chg`.
- R3: The data phase begins when HREADY is high and HTRANS is NONSEQ (2'b10) or SEQ (2'b11). Each cycle with HREADY low during the data phase is a wait cycle, counted from zero at every HREADY-high cycle. Event 1 fires on wait cycle `cfg_ack_lim`+1. A transfer with exactly `cfg_ack_lim` wait cycles does not fire it.
- R4: Event 2 fires when HRESP is ERROR (1) while HREADY is low in a data phase. It fires once for each two-cycle error response.
- R5: A NONSEQ accepted with HREADY high counts as beat 1. Each SEQ accepted with HREADY high adds one beat, and BUSY (2'b01) adds none. Event 3 fires once on the beat numbered `cfg_burst_max`+1.
- R6: Every event sets status bit `status[e]` at the clock edge that ends its cycle, whatever its action. The bit stays set until a cycle with `sts_clr[e]` high; a set in the same cycle wins over the clear.
- R7: `irq` is high exactly while some status bit is set whose action field `cfg_action[2e+1:2e]` is 2'b01.
- R8: An event whose action is 2'b10 makes `rst_req` high for exactly one cycle, the cycle after the event.
- R9: Actions 2'b00 and 2'b11 record status only. They raise neither `irq` nor `rst_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant_chg | input | 1 | High for one cycle when the bus passes to a new master |
| htrans | input | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| hready | input | 1 | Transfer-done indication from the selected slave |
| hresp | input | 1 | Slave response, 1 = ERROR |
| cfg_idle_lim | input | TMR_W | Idle cycles tolerated after a grant change |
| cfg_ack_lim | input | TMR_W | Wait cycles tolerated in one data phase |
| cfg_burst_max | input | BEAT_W | Largest legal burst length in beats |
| cfg_action | input | 8 | Action per event, 2 bits each, event e at [2e+1:2e] |
| sts_clr | input | 4 | Write-one-to-clear strobes for the status bits |
| status | output | 4 | Sticky event bits: 0 idle, 1 ack, 2 error, 3 burst |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Each limit has an off-by-one boundary, and the bench aims at it.
- It stops one cycle or beat short of every limit and checks that nothing fired, then goes one further and checks that the event fired. A counter that compared against the wrong value would fire a cycle early or late.
- It places a non-IDLE transfer between a grant change and a long idle stretch. A detector that never disarmed would report a false owner timeout.
- It inserts a BUSY cycle into a burst. Counting BUSY as a beat would trip the burst event too soon.
- It keeps the ERROR response held for two cycles and checks that the reset request lasts one cycle.
- It checks that the reserved action code stays silent, and that the status bits survive idle cycles and clear only on their own strobe.

// File: rtl/busfault_pkg.sv
package busfault_pkg;
   localparam int NUM_EV   = 4;
   localparam int EV_IDLE  = 0;
   localparam int EV_ACK   = 1;
   localparam int EV_ERR   = 2;
   localparam int EV_BURST = 3;

   typedef enum logic [1:0] {
      ACT_STATUS = 2'b00,
      ACT_IRQ    = 2'b01,
      ACT_RESET  = 2'b10,
      ACT_RSVD   = 2'b11
   } act_e;

   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } trans_e;
endpackage

// File: rtl/bf_stall_cnt.sv
module bf_stall_cnt #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             step,
   input  logic             quit,
   input  logic [TMR_W-1:0] lim,
   output logic             hit
);
   logic             armed;
   logic [TMR_W-1:0] cnt;

   assign hit = armed && !arm && !quit && step && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (arm) begin
         armed <= 1'b1;
         cnt   <= '0;
      end else if (armed) begin
         if (quit || hit) armed <= 1'b0;
         else if (step)   cnt   <= cnt + 1'b1;
      end
   end

   // R1 R3: a stall is reported once per arming
   single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);
endmodule

// File: rtl/bf_burst_len.sv
module bf_burst_len #(
   parameter int BEAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_acc,
   input  logic              next_acc,
   input  logic [BEAT_W-1:0] max_beats,
   output logic              hit
);
   logic [BEAT_W-1:0] beats;
   logic              fired;

   assign hit = next_acc && !fired && (beats >= max_beats);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beats <= '0;
         fired <= 1'b0;
      end else if (first_acc) begin
         beats <= BEAT_W'(1);
         fired <= 1'b0;
      end else if (next_acc) begin
         if (hit) fired <= 1'b1;
         if (beats != '1) beats <= beats + 1'b1;
      end
   end

   // R5: one report per burst
   burst_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);
endmodule

// File: rtl/bf_action.sv
module bf_action
   import busfault_pkg::*;
#(
   parameter int N_EV = NUM_EV
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EV-1:0]   ev,
   input  logic [2*N_EV-1:0] act,
   input  logic [N_EV-1:0]   clr,
   output logic [N_EV-1:0]   status,
   output logic              irq,
   output logic              rst_req
);
   logic [N_EV-1:0] is_irq, is_rst;

   for (genvar e = 0; e < N_EV; e++) begin : g_ev
      assign is_irq[e] = (act[2*e +: 2] == ACT_IRQ);
      assign is_rst[e] = (act[2*e +: 2] == ACT_RESET);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) status[e] <= 1'b0;
         else        status[e] <= (status[e] && !clr[e]) || ev[e];
      end

      // R6
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (status[e] && !clr[e]) |=> status[e]);
   end

   assign irq = |(status & is_irq);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= (|(ev & is_rst)) && !rst_req;
   end

   // R8
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   // R7
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status != '0));
endmodule

// File: rtl/busfault_mon.sv
module busfault_mon
   import busfault_pkg::*;
#(
   parameter int TMR_W  = 16,
   parameter int BEAT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                grant_chg,
   input  logic [1:0]          htrans,
   input  logic                hready,
   input  logic                hresp,
   input  logic [TMR_W-1:0]    cfg_idle_lim,
   input  logic [TMR_W-1:0]    cfg_ack_lim,
   input  logic [BEAT_W-1:0]   cfg_burst_max,
   input  logic [2*NUM_EV-1:0] cfg_action,
   input  logic [NUM_EV-1:0]   sts_clr,
   output logic [NUM_EV-1:0]   status,
   output logic                irq,
   output logic                rst_req
);
   if (TMR_W < 2 || TMR_W > 32) begin : g_bad_tmr
      $error("busfault_mon: TMR_W out of range");
   end
   if (BEAT_W < 2 || BEAT_W > 16) begin : g_bad_beat
      $error("busfault_mon: BEAT_W out of range");
   end

   logic              dphase;
   logic              bus_idle;
   logic [NUM_EV-1:0] ev;

   assign bus_idle = (htrans == TR_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dphase <= 1'b0;
      else if (hready) dphase <= htrans[1];
   end

   bf_stall_cnt #(.TMR_W(TMR_W)) u_idle (
      .clk(clk), .rst_n(rst_n),
      .arm(grant_chg), .step(bus_idle), .quit(!bus_idle),
      .lim(cfg_idle_lim), .hit(ev[EV_IDLE]));

   bf_stall_cnt #(.TMR_W(TMR_W)) u_ack (
      .clk(clk), .rst_n(rst_n),
      .arm(hready), .step(dphase && !hready), .quit(1'b0),
      .lim(cfg_ack_lim), .hit(ev[EV_ACK]));

   assign ev[EV_ERR] = dphase && hresp && !hready;

   bf_burst_len #(.BEAT_W(BEAT_W)) u_burst (
      .clk(clk), .rst_n(rst_n),
      .first_acc(hready && htrans == TR_NONSEQ),
      .next_acc(hready && htrans == TR_SEQ),
      .max_beats(cfg_burst_max), .hit(ev[EV_BURST]));

   bf_action #(.N_EV(NUM_EV)) u_act (
      .clk(clk), .rst_n(rst_n), .ev(ev), .act(cfg_action),
      .clr(sts_clr), .status(status), .irq(irq), .rst_req(rst_req));

   // R4
   err_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp && !hready && dphase) |=> status[EV_ERR]);
endmodule

// File: tb/busfault_mon_bench.sv
`timescale 1ns/100ps
module busfault_mon_bench;
   localparam int TW = 16;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          grant_chg = 1'b0;
   logic [1:0]    htrans = 2'b00;
   logic          hready = 1'b1;
   logic          hresp = 1'b0;
   logic [TW-1:0] cfg_idle_lim = '0;
   logic [TW-1:0] cfg_ack_lim = '0;
   logic [BW-1:0] cfg_burst_max = '0;
   logic [7:0]    cfg_action = '0;
   logic [3:0]    sts_clr = '0;
   logic [3:0]    status;
   logic          irq, rst_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   busfault_mon #(.TMR_W(TW), .BEAT_W(BW)) u_busfault_mon (
      .clk(clk), .rst_n(rst_n), .grant_chg(grant_chg), .htrans(htrans),
      .hready(hready), .hresp(hresp), .cfg_idle_lim(cfg_idle_lim),
      .cfg_ack_lim(cfg_ack_lim), .cfg_burst_max(cfg_burst_max),
      .cfg_action(cfg_action), .sts_clr(sts_clr), .status(status),
      .irq(irq), .rst_req(rst_req));

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus(logic [1:0] tr, logic rdy, logic rsp);
      htrans = tr; hready = rdy; hresp = rsp;
      cyc();
   endtask

   task automatic clear_all();
      sts_clr = 4'hF; cyc(); sts_clr = 4'h0;
   endtask

   task automatic t_reset();
      chk("reset status", status, 4'h0);
      chk("reset irq", irq, 0);
      chk("reset rst_req", rst_req, 0);
   endtask

   task automatic t_idle_timeout();
      cfg_idle_lim = 3; cfg_action = 8'h00;
      grant_chg = 1'b1; bus(2'b00, 1, 0); grant_chg = 1'b0;
      for (int i = 0; i < 3; i++) bus(2'b00, 1, 0);
      chk("R1 no fire after lim idle", status[0], 0);
      bus(2'b00, 1, 0);
      chk("R1 fire on lim+1 idle", status[0], 1);
      chk("R9 status-only no irq", irq, 0);
      chk("R9 status-only no rst", rst_req, 0);
      for (int i = 0; i < 5; i++) bus(2'b00, 1, 0);
      chk("R6 sticky", status[0], 1);
      sts_clr = 4'b0010; cyc(); sts_clr = 4'h0;
      chk("R6 other clear ignored", status[0], 1);
      sts_clr = 4'b0001; cyc(); sts_clr = 4'h0;
      chk("R6 w1c", status[0], 0);
   endtask

   task automatic t_idle_disarm();
      cfg_idle_lim = 2;
      grant_chg = 1'b1; bus(2'b00, 1, 0); grant_chg = 1'b0;
      bus(2'b00, 1, 0);
      bus(2'b10, 1, 0);
      for (int i = 0; i < 8; i++) bus(2'b00, 1, 0);
      chk("R2 activity disarms", status[0], 0);
      grant_chg = 1'b1; bus(2'b00, 1, 0); grant_chg = 1'b0;
      for (int i = 0; i < 3; i++) bus(2'b00, 1, 0);
      chk("R2 rearm on grant", status[0], 1);
      clear_all();
   endtask

   task automatic t_ack_timeout();
      cfg_ack_lim = 2; cfg_action = 8'b00_00_01_00;
      bus(2'b10, 1, 0);
      bus(2'b00, 0, 0); bus(2'b00, 0, 0);
      bus(2'b00, 1, 0);
      chk("R3 lim waits no fire", status[1], 0);
      bus(2'b10, 1, 0);
      bus(2'b00, 0, 0); bus(2'b00, 0, 0);
      chk("R3 before lim+1", status[1], 0);
      bus(2'b00, 0, 0);
      chk("R3 fire on lim+1 wait", status[1], 1);
      chk("R7 irq for irq action", irq, 1);
      bus(2'b00, 1, 0);
      sts_clr = 4'b0010; cyc(); sts_clr = 4'h0;
      chk("R7 irq drops on clear", irq, 0);
   endtask

   task automatic t_slave_err();
      cfg_ack_lim = 10; cfg_action = 8'b00_10_00_00;
      bus(2'b10, 1, 0);
      bus(2'b00, 0, 1);
      chk("R4 error recorded", status[2], 1);
      chk("R8 rst_req pulse high", rst_req, 1);
      chk("R7 reset action no irq", irq, 0);
      bus(2'b00, 1, 1);
      chk("R8 rst_req one cycle", rst_req, 0);
      bus(2'b00, 1, 0);
      chk("R8 rst_req stays low", rst_req, 0);
      clear_all();
      chk("R4 cleared", status[2], 0);
      cfg_action = 8'b00_11_00_00;
      bus(2'b10, 1, 0);
      bus(2'b00, 0, 1);
      chk("R9 reserved records", status[2], 1);
      chk("R9 reserved no rst", rst_req, 0);
      chk("R9 reserved no irq", irq, 0);
      bus(2'b00, 1, 1);
      bus(2'b00, 1, 0);
      clear_all();
   endtask

   task automatic t_burst();
      cfg_burst_max = 4; cfg_action = 8'b01_00_00_00;
      bus(2'b10, 1, 0);
      bus(2'b11, 1, 0);
      bus(2'b01, 1, 0);
      bus(2'b11, 1, 0);
      bus(2'b11, 0, 0);
      bus(2'b11, 1, 0);
      chk("R5 max beats no fire", status[3], 0);
      bus(2'b11, 1, 0);
      chk("R5 fire on max+1 beat", status[3], 1);
      chk("R7 burst irq", irq, 1);
      bus(2'b00, 1, 0);
      clear_all();
      bus(2'b10, 1, 0);
      for (int i = 0; i < 3; i++) bus(2'b11, 1, 0);
      bus(2'b00, 1, 0);
      chk("R5 new burst recounts", status[3], 0);
   endtask

   initial begin
      cfg_ack_lim = 16'd100; cfg_burst_max = 8'd15;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_idle_timeout();
      t_idle_disarm();
      t_ack_timeout();
      t_slave_err();
      t_burst();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule